// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port with an APB-style register interface. Its data register does not take a plain offset. Address bits [9:2] of any aligned access in the low window act as a per-line mask. A read through the window returns only the selected lines and zeroes the rest. A write through the window changes only the selected output bits. Software can therefore drive one pin high or low with a single store and no read-modify-write.

A second register sets the direction of each line: 1 makes the line an output and 0 makes it an input. On the pad side, the block drives an output value and an output enable for each line and receives an input value for each line. Each pad input passes through a synchroniser before software can read it. When a line is an output, a read returns the value the block drives. When a line is an input, a read returns the synchronised pad level. The bus completes every transfer without wait states and never signals an error.

Top module: `gpio_amask_port`

## Requirements
- R1: While reset is asserted and after it is released, every line is an input (pad_oe = 0x00), the output data is zero (pad_out = 0x00), and a read of the direction register returns 0x00.
- R2: A read at an aligned offset in 0x000..0x3FC returns, for each line n, the line's value when paddr[n+2] is 1 and 0 when paddr[n+2] is 0.
- R3: A write at an aligned offset in 0x000..0x3FC sets output bit n to pwdata[n] only where paddr[n+2] is 1. Every other output bit keeps its value, so a write at offset 0x000 changes nothing.
- R4: The direction register sits at offset 0x400 and can be read and written. Bit n = 1 makes line n an output. pad_oe equals the register from the cycle after the write.
- R5: pad_out bit n equals output data bit n in every direction setting.
- R6: For an output line, a read returns the driven output bit. For an input line, a read returns the pad level sampled through two flops, so a pad change is readable two clock edges after it arrives.
- R7: For pin n, writing (1<<n) at offset (1<<(n+2)) drives that pin high and writing 0 there drives it low. No other pin changes.
- R8: Reads at any other offset, including unaligned offsets, return 0x00. Writes at those offsets change neither pad_out nor pad_oe.
- R9: pready is always 1 and pslverr is always 0.
- R10: State changes only in the access phase (psel and penable both high with pwrite). A setup phase that is not followed by an access phase leaves the pads unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the access |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid during a selected read |
| pready | output | 1 | Transfer complete, constant 1 |
| pslverr | output | 1 | Error response, constant 0 |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
Two functions can fall in the same cycle: a masked write updating output bits, and a new pad level moving through the input synchroniser on the input lines. The bench provokes this by changing pad_in at the start of a full-mask data write, while the low nibble is set as outputs and the high nibble as inputs. A full-mask read that follows must return the written low nibble merged with the new high pad nibble. Any mix-up between the output path and the input path shows up as a wrong nibble in that read.

// File: rtl/gpio_amask_pkg.sv
package gpio_amask_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_DATA = 2'd1,
      RGN_DIR  = 2'd2
   } gpio_rgn_e;

endpackage

// File: rtl/gpio_amask_decode.sv
module gpio_amask_decode
   import gpio_amask_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output gpio_rgn_e         rgn,
   output logic [LINES-1:0]  mask
);
   localparam int MSB_LO = LINES + 2;
   localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << MSB_LO;

   logic aligned;
   logic in_window;

   assign aligned   = (addr[1:0] == 2'b00);
   assign in_window = (addr[ADDR_W-1:MSB_LO] == '0);
   assign mask      = addr[MSB_LO-1:2];

   always_comb begin
      if (aligned && in_window)  rgn = RGN_DATA;
      else if (addr == DIR_OFS)  rgn = RGN_DIR;
      else                       rgn = RGN_NONE;
   end
endmodule

// File: rtl/gpio_amask_sync.sv
module gpio_amask_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_amask_bank.sv
module gpio_amask_bank #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data,
   input  logic             wr_dir,
   input  logic [LINES-1:0] mask,
   input  logic [LINES-1:0] wdata,
   output logic [LINES-1:0] out_q,
   output logic [LINES-1:0] dir_q
);
   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 out_q[i] <= 1'b0;
            else if (wr_data && mask[i]) out_q[i] <= wdata[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
   end
endmodule

// File: rtl/gpio_amask_port.sv
module gpio_amask_port
   import gpio_amask_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 pclk,
   input  logic                 presetn,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [NUM_LINES-1:0] pwdata,
   output logic [NUM_LINES-1:0] prdata,
   output logic                 pready,
   output logic                 pslverr,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe
);
   generate
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("NUM_LINES must be at least 1");
      end
      if (ADDR_W < NUM_LINES + 3) begin : g_bad_addr
         $error("ADDR_W too narrow for mask window and direction offset");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   gpio_rgn_e          rgn;
   logic [NUM_LINES-1:0] mask;
   logic [NUM_LINES-1:0] out_q;
   logic [NUM_LINES-1:0] dir_q;
   logic [NUM_LINES-1:0] pin_sync;
   logic [NUM_LINES-1:0] line_val;
   logic                 acc_wr;
   logic                 rd_sel;

   gpio_amask_decode #(.LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dec (
      .addr (paddr),
      .rgn  (rgn),
      .mask (mask)
   );

   assign acc_wr = psel && penable && pwrite;

   gpio_amask_bank #(.LINES(NUM_LINES)) u_bank (
      .clk     (pclk),
      .rst_n   (presetn),
      .wr_data (acc_wr && (rgn == RGN_DATA)),
      .wr_dir  (acc_wr && (rgn == RGN_DIR)),
      .mask    (mask),
      .wdata   (pwdata),
      .out_q   (out_q),
      .dir_q   (dir_q)
   );

   gpio_amask_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (pclk),
      .rst_n (presetn),
      .d     (pad_in),
      .q     (pin_sync)
   );

   assign line_val = (dir_q & out_q) | (~dir_q & pin_sync);
   assign rd_sel   = psel && !pwrite;

   always_comb begin
      prdata = '0;
      if (rd_sel) begin
         unique case (rgn)
            RGN_DATA: prdata = line_val & mask;
            RGN_DIR:  prdata = dir_q;
            default:  prdata = '0;
         endcase
      end
   end

   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign pad_out = out_q;
   assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_amask_chk.sv
module gpio_amask_chk #(
   parameter int NUM_LINES = 8,
   parameter int ADDR_W    = 12
) (
   input logic                 pclk,
   input logic                 presetn,
   input logic                 psel,
   input logic                 penable,
   input logic                 pwrite,
   input logic [ADDR_W-1:0]    paddr,
   input logic [NUM_LINES-1:0] pwdata,
   input logic [NUM_LINES-1:0] prdata,
   input logic [NUM_LINES-1:0] pad_out,
   input logic [NUM_LINES-1:0] pad_oe
);
   localparam int HI = NUM_LINES + 2;
   localparam logic [ADDR_W-1:0] DIR_AT = ADDR_W'(1) << HI;

   logic                 c_win;
   logic                 c_dir;
   logic [NUM_LINES-1:0] c_mask;
   logic                 c_wr;

   assign c_win  = (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:HI] == '0);
   assign c_dir  = (paddr == DIR_AT);
   assign c_mask = paddr[HI-1:2];
   assign c_wr   = psel && penable && pwrite;

   AST_READ_MASKED: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && c_win) |-> ((prdata & ~c_mask) == '0)); // R2

   AST_MASKED_SET: assert property (@(posedge pclk) disable iff (!presetn)
      (c_wr && c_win) |=> ((pad_out & $past(c_mask)) == ($past(pwdata) & $past(c_mask)))); // R3

   AST_UNMASKED_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
      (c_wr && c_win) |=> (((pad_out ^ $past(pad_out)) & ~$past(c_mask)) == '0)); // R3

   AST_DIR_LOAD: assert property (@(posedge pclk) disable iff (!presetn)
      (c_wr && c_dir) |=> (pad_oe == $past(pwdata))); // R4

   AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && !c_win && !c_dir) |-> (prdata == '0)); // R8

   AST_IDLE_STABLE: assert property (@(posedge pclk) disable iff (!presetn)
      !c_wr |=> ($stable(pad_out) && $stable(pad_oe))); // R10
endmodule

bind gpio_amask_port gpio_amask_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
   .pclk    (pclk),
   .presetn (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .pwdata  (pwdata),
   .prdata  (prdata),
   .pad_out (pad_out),
   .pad_oe  (pad_oe)
);

// File: tb/gpio_amask_port_tb.sv
`timescale 1ns/1ps
module gpio_amask_port_tb;
   logic        clk = 1'b0;
   logic        rstn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [7:0]  pwdata = '0;
   logic [7:0]  pad_in = '0;
   logic [7:0]  prdata;
   logic        pready;
   logic        pslverr;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   gpio_amask_port u_dut (
      .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per read access phase
   always @(negedge clk) begin
      if (psel && penable) begin
         check({7'd0, pready}, 8'd1, "R9 pready");
         check({7'd0, pslverr}, 8'd0, "R9 pslverr");
         if (!pwrite) begin
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL scoreboard: got %02h expected none", prdata);
            end else begin
               check(prdata, exp_q.pop_front(), tag_q.pop_front());
            end
         end
      end
   end

   task automatic apb_write(input logic [11:0] a, input logic [7:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(posedge clk); #1 penable = 1'b1;
      @(posedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [11:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(posedge clk); #1 penable = 1'b1;
      @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(pad_oe, 8'h00, "R1 oe in reset");
      check(pad_out, 8'h00, "R1 out in reset");
      rstn = 1'b1;
      @(posedge clk); #1;
      apb_read(12'h400, 8'h00, "R1 dir after reset");
      apb_read(12'h3FC, 8'h00, "R6 idle inputs");

      pad_in = 8'hA5;
      repeat (4) @(posedge clk); #1;
      apb_read(12'h3FC, 8'hA5, "R6 input lines");
      apb_read(12'h03C, 8'h05, "R2 low mask");
      apb_read(12'h3C0, 8'hA0, "R2 high mask");

      apb_write(12'h400, 8'h0F);
      check(pad_oe, 8'h0F, "R4 oe follows dir");
      apb_read(12'h400, 8'h0F, "R4 dir readback");

      apb_write(12'h3FC, 8'h3C);
      check(pad_out, 8'h3C, "R5 full write");
      apb_read(12'h3FC, 8'hAC, "R6 mixed read");

      apb_write(12'h00C, 8'hFF);
      check(pad_out, 8'h3F, "R3 set masked low");
      apb_write(12'h0C0, 8'h00);
      check(pad_out, 8'h0F, "R3 clear masked");
      apb_write(12'h000, 8'hFF);
      check(pad_out, 8'h0F, "R3 zero mask");

      apb_write(12'h100, 8'h40);
      check(pad_out, 8'h4F, "R7 pin6 high");
      apb_write(12'h004, 8'h00);
      check(pad_out, 8'h4E, "R7 pin0 low");

      apb_write(12'h404, 8'hFF);
      check(pad_out, 8'h4E, "R8 write ignored out");
      check(pad_oe, 8'h0F, "R8 write ignored oe");
      apb_write(12'h3FD, 8'hFF);
      check(pad_out, 8'h4E, "R8 unaligned ignored");
      apb_read(12'h404, 8'h00, "R8 read above dir");
      apb_read(12'h800, 8'h00, "R8 read high");

      // setup phase only, no access phase
      psel = 1'b1; pwrite = 1'b1; paddr = 12'h3FC; pwdata = 8'h00;
      @(posedge clk); #1 psel = 1'b0; pwrite = 1'b0;
      @(posedge clk); #1;
      check(pad_out, 8'h4E, "R10 setup only");

      // pad edge and masked write in the same cycle
      pad_in = 8'h5A;
      apb_write(12'h3FC, 8'h0F);
      check(pad_out, 8'h0F, "R5 concurrent write");
      apb_read(12'h3FC, 8'h5F, "R6 concurrent merge");

      apb_write(12'h400, 8'h00);
      check(pad_oe, 8'h00, "R4 back to inputs");
      check(pad_out, 8'h0F, "R5 out kept as input");
      apb_read(12'h3FC, 8'h5A, "R6 all inputs");

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule